// File: doc/BRIEF.md
# CAN Receive Rule Acceptance Filter

This block decides whether an incoming CAN frame header is kept and where it goes. It holds a table of 16 programmable receive rules. Each rule stores an identifier, the IDE and RTR flags, a compare mask for each of these, a loopback-select bit, two routing destinations and a 12-bit label. A frame is presented for one cycle with a valid pulse. The block then reports whether any rule matched, the index of the winning rule, the routing and the label of that rule.

Frame origin decides which rules apply. With mirror mode on, frames from other nodes use only rules with the loopback bit clear, and frames sent by this node use only rules with it set. With mirror mode off, frames from this node are never accepted and every rule applies to frames from other nodes. Rules are loaded through a plain address/data/write-enable port. The result is registered, so it appears one clock after the frame pulse and is held until the next one.

Top module: `rx_rule_filter`

## Requirements
- R1: After reset all result outputs are 0 and every rule field is 0, so every rule compares nothing and carries no routing.
- R2: `res_valid_o` is 1 in exactly the cycle after each cycle with `frm_valid_i` = 1, and 0 otherwise.
- R3: A rule matches when every header bit whose mask bit is 1 equals the rule's bit. This covers the 29 ID bits, IDE and RTR. Header bits whose mask bit is 0 are ignored.
- R4: When several eligible rules match, the rule with the lowest index is reported in `res_rule_o`.
- R5: A frame that matches no eligible rule gives `res_accept_o` = 0, with rule index, buffer valid, buffer index, FIFO select and label all 0.
- R6: With `mirror_en_i` = 1, a frame with `frm_self_i` = 0 is checked only against rules whose loopback bit is 0. A frame with `frm_self_i` = 1 is checked only against rules whose loopback bit is 1.
- R7: With `mirror_en_i` = 0, a frame with `frm_self_i` = 1 is rejected. A frame with `frm_self_i` = 0 is checked against all rules, whatever their loopback bit.
- R8: An accepted frame reports the winning rule's buffer valid bit, 7-bit buffer index, 3-bit FIFO select and 12-bit label.
- R9: A rule write in the same cycle as `frm_valid_i` does not affect that frame. It does affect the next frame.
- R10: `wr_addr_i` = {rule index[3:0], field[1:0]}. Field 0 is the identifier word: data[28:0] ID, [29] IDE, [30] RTR, [31] loopback. Field 1 is the mask word: [28:0] ID mask, [29] IDE mask, [30] RTR mask. Field 2 is the routing word: [6:0] buffer index, [7] buffer valid, [10:8] FIFO select, [27:16] label. Writes to field 3 have no effect.
- R11: All result outputs hold their value in cycles after which `frm_valid_i` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Rule write strobe |
| wr_addr_i | input | 6 | Rule index and field select |
| wr_data_i | input | 32 | Rule field data |
| mirror_en_i | input | 1 | Mirror mode enable |
| frm_valid_i | input | 1 | Frame header present this cycle |
| frm_id_i | input | 29 | Frame identifier |
| frm_ide_i | input | 1 | Frame IDE flag |
| frm_rtr_i | input | 1 | Frame RTR flag |
| frm_self_i | input | 1 | Frame was sent by this node |
| res_valid_o | output | 1 | Result strobe |
| res_accept_o | output | 1 | Frame accepted |
| res_rule_o | output | 4 | Winning rule index |
| res_buf_valid_o | output | 1 | Receive buffer destination valid |
| res_buf_idx_o | output | 7 | Receive buffer index |
| res_fifo_sel_o | output | 3 | FIFO select bits |
| res_label_o | output | 12 | Label of the winning rule |

## Verification
The assertions check on every cycle the one-cycle timing of the result strobe, that results hold between frames, that a rejected result carries no routing or label, and that frames from this node are refused while mirror mode is off. Mask comparison, lowest-index priority, loopback eligibility under mirror mode, the routing and label taken from the winner, the same-cycle write rule and the field layout depend on the table contents. Only the bench scenarios show these, by comparing against a behavioural model of the rule table.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ID_W    = 29;
  localparam int BIDX_W  = 7;
  localparam int FIFO_W  = 3;
  localparam int LABEL_W = 12;
  localparam int DATA_W  = 32;
  localparam int FLD_W   = 2;

  typedef enum logic [FLD_W-1:0] {
    FLD_IDENT = 2'd0,
    FLD_MASK  = 2'd1,
    FLD_ROUTE = 2'd2,
    FLD_NONE  = 2'd3
  } fld_e;

  // bit positions in the routing word
  localparam int RT_BVLD  = BIDX_W;
  localparam int RT_FIFO  = BIDX_W + 1;
  localparam int RT_LABEL = 16;

  typedef struct packed {
    logic [ID_W-1:0]    id;
    logic               ide;
    logic               rtr;
    logic               lb;
    logic [ID_W-1:0]    id_m;
    logic               ide_m;
    logic               rtr_m;
    logic [BIDX_W-1:0]  bidx;
    logic               bvld;
    logic [FIFO_W-1:0]  fifo;
    logic [LABEL_W-1:0] label;
  } rule_t;
endpackage

// File: rtl/rxf_rule_table.sv
module rxf_rule_table
  import rxf_pkg::*;
#(
  parameter int NUM_RULES = 16,
  localparam int RIDX_W = $clog2(NUM_RULES),
  localparam int ADDR_W = RIDX_W + FLD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output rule_t             rules_o [NUM_RULES]
);
  logic [RIDX_W-1:0] wr_rule;
  fld_e              wr_fld;

  assign wr_rule = wr_addr_i[ADDR_W-1:FLD_W];
  assign wr_fld  = fld_e'(wr_addr_i[FLD_W-1:0]);

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    rule_t q;
    logic  hit;
    assign hit = wr_en_i && (wr_rule == RIDX_W'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (hit) begin
        unique case (wr_fld)
          FLD_IDENT: begin
            q.id  <= wr_data_i[ID_W-1:0];
            q.ide <= wr_data_i[ID_W];
            q.rtr <= wr_data_i[ID_W+1];
            q.lb  <= wr_data_i[ID_W+2];
          end
          FLD_MASK: begin
            q.id_m  <= wr_data_i[ID_W-1:0];
            q.ide_m <= wr_data_i[ID_W];
            q.rtr_m <= wr_data_i[ID_W+1];
          end
          FLD_ROUTE: begin
            q.bidx  <= wr_data_i[BIDX_W-1:0];
            q.bvld  <= wr_data_i[RT_BVLD];
            q.fifo  <= wr_data_i[RT_FIFO +: FIFO_W];
            q.label <= wr_data_i[RT_LABEL +: LABEL_W];
          end
          default: ;
        endcase
      end
    end

    assign rules_o[r] = q;
  end
endmodule

// File: rtl/rxf_rule_match.sv
module rxf_rule_match
  import rxf_pkg::*;
#(
  parameter int NUM_RULES = 16,
  localparam int CMP_W = ID_W + 2
) (
  input  rule_t           rules_i [NUM_RULES],
  input  logic [ID_W-1:0] id_i,
  input  logic            ide_i,
  input  logic            rtr_i,
  input  logic            self_i,
  input  logic            mirror_i,
  output logic [NUM_RULES-1:0] hit_o
);
  logic [CMP_W-1:0] hdr;
  assign hdr = {rtr_i, ide_i, id_i};

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_cmp
    logic [CMP_W-1:0] ref_v, msk_v;
    logic             eq, elig;
    assign ref_v = {rules_i[r].rtr, rules_i[r].ide, rules_i[r].id};
    assign msk_v = {rules_i[r].rtr_m, rules_i[r].ide_m, rules_i[r].id_m};
    assign eq    = ((hdr ^ ref_v) & msk_v) == '0;
    // mirror on: loopback bit must equal origin; off: only foreign frames
    assign elig  = mirror_i ? (rules_i[r].lb == self_i) : !self_i;
    assign hit_o[r] = eq && elig;
  end
endmodule

// File: rtl/rxf_prio_pick.sv
module rxf_prio_pick #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rx_rule_filter.sv
module rx_rule_filter
  import rxf_pkg::*;
#(
  parameter int NUM_RULES = 16,
  localparam int RIDX_W = $clog2(NUM_RULES),
  localparam int ADDR_W = RIDX_W + FLD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               mirror_en_i,
  input  logic               frm_valid_i,
  input  logic [ID_W-1:0]    frm_id_i,
  input  logic               frm_ide_i,
  input  logic               frm_rtr_i,
  input  logic               frm_self_i,
  output logic               res_valid_o,
  output logic               res_accept_o,
  output logic [RIDX_W-1:0]  res_rule_o,
  output logic               res_buf_valid_o,
  output logic [BIDX_W-1:0]  res_buf_idx_o,
  output logic [FIFO_W-1:0]  res_fifo_sel_o,
  output logic [LABEL_W-1:0] res_label_o
);
  rule_t                 rules [NUM_RULES];
  logic [NUM_RULES-1:0]  hit;
  logic                  found;
  logic [RIDX_W-1:0]     win;
  rule_t                 wr_rule;

  rxf_rule_table #(.NUM_RULES(NUM_RULES)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rules_o   (rules)
  );

  rxf_rule_match #(.NUM_RULES(NUM_RULES)) u_match (
    .rules_i  (rules),
    .id_i     (frm_id_i),
    .ide_i    (frm_ide_i),
    .rtr_i    (frm_rtr_i),
    .self_i   (frm_self_i),
    .mirror_i (mirror_en_i),
    .hit_o    (hit)
  );

  rxf_prio_pick #(.N(NUM_RULES)) u_pick (
    .req_i   (hit),
    .found_o (found),
    .idx_o   (win)
  );

  assign wr_rule = rules[win];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= frm_valid_i;
    end
  end

  // table is read before the same-edge write lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_accept_o    <= 1'b0;
      res_rule_o      <= '0;
      res_buf_valid_o <= 1'b0;
      res_buf_idx_o   <= '0;
      res_fifo_sel_o  <= '0;
      res_label_o     <= '0;
    end else if (frm_valid_i) begin
      res_accept_o    <= found;
      res_rule_o      <= found ? win : '0;
      res_buf_valid_o <= found && wr_rule.bvld;
      res_buf_idx_o   <= found ? wr_rule.bidx  : '0;
      res_fifo_sel_o  <= found ? wr_rule.fifo  : '0;
      res_label_o     <= found ? wr_rule.label : '0;
    end
  end
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk
  import rxf_pkg::*;
#(
  parameter int RIDX_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mirror_en_i,
  input logic               frm_valid_i,
  input logic               frm_self_i,
  input logic               res_valid_o,
  input logic               res_accept_o,
  input logic [RIDX_W-1:0]  res_rule_o,
  input logic               res_buf_valid_o,
  input logic [BIDX_W-1:0]  res_buf_idx_o,
  input logic [FIFO_W-1:0]  res_fifo_sel_o,
  input logic [LABEL_W-1:0] res_label_o
);
  // R2
  valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |=> res_valid_o);
  // R2
  valid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid_i |=> !res_valid_o);
  // R5
  reject_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_accept_o) |-> (res_rule_o == '0 && !res_buf_valid_o
      && res_buf_idx_o == '0 && res_fifo_sel_o == '0 && res_label_o == '0));
  // R7
  self_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && frm_self_i && !mirror_en_i) |=> !res_accept_o);
  // R11
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid_i |=> ($stable(res_accept_o) && $stable(res_rule_o)
      && $stable(res_label_o) && $stable(res_buf_idx_o)
      && $stable(res_buf_valid_o) && $stable(res_fifo_sel_o)));
endmodule

bind rx_rule_filter rxf_chk #(.RIDX_W(RIDX_W)) u_rxf_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .mirror_en_i     (mirror_en_i),
  .frm_valid_i     (frm_valid_i),
  .frm_self_i      (frm_self_i),
  .res_valid_o     (res_valid_o),
  .res_accept_o    (res_accept_o),
  .res_rule_o      (res_rule_o),
  .res_buf_valid_o (res_buf_valid_o),
  .res_buf_idx_o   (res_buf_idx_o),
  .res_fifo_sel_o  (res_fifo_sel_o),
  .res_label_o     (res_label_o)
);

// File: tb/rx_rule_filter_test.sv
module rx_rule_filter_test;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [5:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic        mirror = 0, fv = 0, ide = 0, rtr = 0, self_f = 0;
  logic [28:0] fid = 0;
  logic        r_valid, r_acc, r_bvld;
  logic [3:0]  r_rule;
  logic [6:0]  r_bidx;
  logic [2:0]  r_fifo;
  logic [11:0] r_label;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  rx_rule_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .mirror_en_i(mirror), .frm_valid_i(fv),
    .frm_id_i(fid), .frm_ide_i(ide), .frm_rtr_i(rtr), .frm_self_i(self_f),
    .res_valid_o(r_valid), .res_accept_o(r_acc), .res_rule_o(r_rule),
    .res_buf_valid_o(r_bvld), .res_buf_idx_o(r_bidx),
    .res_fifo_sel_o(r_fifo), .res_label_o(r_label)
  );

  // behavioural model: one word per field, as written
  logic [31:0] m_ident [16];
  logic [31:0] m_mask  [16];
  logic [31:0] m_route [16];
  logic e_valid, e_acc, e_bvld;
  logic [3:0] e_rule;
  logic [6:0] e_bidx;
  logic [2:0] e_fifo;
  logic [11:0] e_label;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        m_ident[i] = 0; m_mask[i] = 0; m_route[i] = 0;
      end
      {e_valid, e_acc, e_bvld, e_rule, e_bidx, e_fifo, e_label} = '0;
    end else begin
      e_valid = fv;
      if (fv) begin
        int w;
        w = -1;
        for (int i = 15; i >= 0; i--) begin
          logic [31:0] hdr;
          bit ok;
          hdr = {m_ident[i][31], rtr, ide, fid};
          ok = (((hdr ^ m_ident[i]) & {1'b0, m_mask[i][30:0]}) == 0);
          if (mirror) ok = ok && (m_ident[i][31] == self_f);
          else ok = ok && !self_f;
          if (ok) w = i;
        end
        if (w < 0) {e_acc, e_bvld, e_rule, e_bidx, e_fifo, e_label} = '0;
        else begin
          e_acc = 1; e_rule = w[3:0];
          e_bidx = m_route[w][6:0]; e_bvld = m_route[w][7];
          e_fifo = m_route[w][10:8]; e_label = m_route[w][27:16];
        end
      end
      if (wr_en) begin
        case (wr_addr[1:0])
          2'd0: m_ident[wr_addr[5:2]] = wr_data;
          2'd1: m_mask[wr_addr[5:2]]  = wr_data & 32'h7FFF_FFFF;
          2'd2: m_route[wr_addr[5:2]] = wr_data & 32'h0FFF_07FF;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk({r_valid, r_acc, r_rule, r_bvld, r_bidx, r_fifo, r_label} ==
        {e_valid, e_acc, e_rule, e_bvld, e_bidx, e_fifo, e_label}, cur_req,
        {r_valid, r_acc, r_rule, r_bvld, r_bidx, r_fifo, r_label},
        {e_valid, e_acc, e_rule, e_bvld, e_bidx, e_fifo, e_label});
  end

  task automatic wr(int rule, int fld, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = {rule[3:0], fld[1:0]}; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic frame(logic [28:0] id, bit i, bit r, bit s, bit m);
    @(negedge clk);
    fv = 1; fid = id; ide = i; rtr = r; self_f = s; mirror = m;
    @(negedge clk);
    fv = 0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero after reset
    chk({r_valid, r_acc, r_rule, r_bvld, r_bidx, r_fifo, r_label} == 0, "R1",
        {r_valid, r_acc, r_rule, r_label}, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: zero table compares nothing -> rule 0 takes any foreign frame
    frame(29'h1234, 0, 0, 0, 0);
    chk(r_acc && r_rule == 0 && r_label == 0, "R1", {r_acc, r_rule}, 12'h100);

    cur_req = "R10";
    for (int i = 0; i < 16; i++) begin
      wr(i, 0, {(i >= 12) ? 1'b1 : 1'b0, 2'b00, 29'h100 + 29'(i)});
      wr(i, 1, 32'h7FFF_FFFF);
      wr(i, 2, {4'h0, 12'hA00 + 12'(i), 5'h0, 3'(i), 1'(i % 2), 7'(i + 3)});
      wr(i, 3, 32'hFFFF_FFFF);
    end
    // R10 R8: exact hit on rule 5, field 3 writes did nothing
    cur_req = "R8";
    frame(29'h105, 0, 0, 0, 1);
    chk(r_acc && r_rule == 5 && r_label == 12'hA05 && r_bidx == 8 &&
        r_bvld && r_fifo == 5, "R8", {r_rule, r_label}, {4'd5, 12'hA05});
    chk(r_acc, "R10", r_acc, 1);

    // R3: IDE mismatch on a compared bit rejects
    cur_req = "R3";
    frame(29'h107, 1, 0, 0, 1);
    chk(!r_acc, "R3", r_acc, 0);
    // R5: rejection clears routing
    cur_req = "R5";
    chk(r_label == 0 && r_bidx == 0 && !r_bvld && r_fifo == 0 && r_rule == 0,
        "R5", r_label, 0);
    // R3: clear RTR mask on rule 7 -> RTR ignored
    cur_req = "R3";
    wr(7, 1, 32'h3FFF_FFFF);
    frame(29'h107, 0, 1, 0, 1);
    chk(r_acc && r_rule == 7, "R3", r_rule, 7);

    // R4: widen rule 2 to the whole 0x1xx range -> wins over 5
    cur_req = "R4";
    wr(2, 1, 32'h7FFF_FF00);
    frame(29'h105, 0, 0, 0, 1);
    chk(r_rule == 2, "R4", r_rule, 2);
    frame(29'h101, 0, 0, 0, 1);
    chk(r_rule == 1, "R4", r_rule, 1);

    // R6: mirror on
    cur_req = "R6";
    frame(29'h10D, 0, 0, 1, 1);
    chk(r_acc && r_rule == 13, "R6", r_rule, 13);
    frame(29'h105, 0, 0, 1, 1);
    chk(!r_acc, "R6", r_acc, 0);
    wr(2, 1, 32'h7FFF_FFFF);
    frame(29'h10D, 0, 0, 0, 1);
    chk(!r_acc, "R6", r_acc, 0);

    // R7: mirror off
    cur_req = "R7";
    frame(29'h10D, 0, 0, 1, 0);
    chk(!r_acc, "R7", r_acc, 0);
    frame(29'h10D, 0, 0, 0, 0);
    chk(r_acc && r_rule == 13, "R7", r_rule, 13);

    // R9: write lands the same cycle as frame
    cur_req = "R9";
    @(negedge clk);
    fv = 1; fid = 29'h555; ide = 0; rtr = 0; self_f = 0; mirror = 1;
    wr_en = 1; wr_addr = {4'd9, 2'd0}; wr_data = 32'h0000_0555;
    @(negedge clk);
    fv = 0; wr_en = 0;
    chk(!r_acc, "R9", r_acc, 0);
    frame(29'h555, 0, 0, 0, 1);
    chk(r_acc && r_rule == 9, "R9", r_rule, 9);

    // R11: outputs hold while idle
    cur_req = "R11";
    repeat (4) @(negedge clk);
    chk(!r_valid && r_acc && r_rule == 9, "R11", r_rule, 9);

    // mixed sweep, model decides
    cur_req = "R2";
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      fv = ($urandom % 3) != 0;
      fid = ($urandom % 2) ? 29'h100 + 29'($urandom % 20) : 29'($urandom);
      ide = ($urandom % 4) == 0; rtr = ($urandom % 4) == 0;
      self_f = $urandom % 2; mirror = $urandom % 2;
      wr_en = ($urandom % 8) == 0;
      wr_addr = 6'($urandom);
      wr_data = $urandom;
    end
    @(negedge clk);
    fv = 0; wr_en = 0;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule